// File: doc/BRIEF.md
# Ethernet receive destination-address filter

This block sits beside a receive datapath and decides, for every incoming frame, whether the frame should be kept. It watches the first six bytes of the frame, which carry the 48-bit destination address, as they stream past with a start-of-frame marker and a byte-valid strobe. It compares a unicast destination against a programmed station address. It checks a multicast destination against a 64-entry hash table indexed by six bits of a CRC-32 computed over the address. Broadcast and multicast frames are flagged.

A host programs a mode word, the station address and the two 32-bit halves of the hash table through a small write-only register port. Once the sixth address byte has been taken, the block raises a one-cycle result strobe carrying the accept decision and the multicast flag. The downstream logic uses that strobe to keep or drop the frame.

Top module: `rx_addr_filter`

## Requirements
- R1: After a synchronous reset, `res_valid`, `res_accept` and `res_mcast` are 0, and they stay 0 until a complete address has been received.
- R2: A frame starts with a byte that has `rx_sof` and `rx_vld` both high. `res_valid` is high for exactly one cycle, one clock after the edge that takes the sixth address byte. Valid bytes after the sixth are ignored until the next start-of-frame. A start-of-frame in the middle of an address discards the partial address.
- R3: `res_mcast` equals bit 0 of the first address byte. The first byte is carried in bits 7:0 of the 48-bit address as written to the station registers.
- R4: The hash index is bits 31:26 of a CRC-32 over the six address bytes. The CRC uses polynomial 0x04C11DB7, an initial value of all ones, bits taken LSB first within each byte, and no final inversion. Index bit 5 selects the high table word (1) or the low word (0), and index bits 4:0 select the bit within that word.
- R5: With mode bit 0 (promiscuous) set, every frame is accepted, whatever the other mode bits and tables hold.
- R6: With mode bit 1 (pass all multicast) set, every multicast frame is accepted, and unicast frames still need an exact station match.
- R7: With mode bit 2 (hash) set, a non-broadcast multicast frame is accepted exactly when its hash table bit is 1, and a unicast frame needs an exact station match. A table of all ones accepts every multicast frame.
- R8: With mode bits 0 to 2 clear, only unicast frames equal to the station address and broadcast frames are accepted.
- R9: The all-ones broadcast address is accepted unless mode bit 3 (broadcast block) is set. Promiscuous mode overrides that bit.
- R10: Register offsets on `reg_addr` are: 0 mode (bits 3:0), 1 station bytes 0..3 (byte 0 in bits 7:0), 2 station bytes 4..5 in bits 15:0, 3 hash low word, 4 hash high word. Writes to offsets 5 to 7 have no effect.
- R11: Cycles with `rx_vld` low inside an address are skipped and do not disturb the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 32 | Register write data |
| rx_sof | input | 1 | Marks the first address byte |
| rx_vld | input | 1 | Byte valid |
| rx_byte | input | 8 | Received byte |
| res_valid | output | 1 | One-cycle result strobe |
| res_accept | output | 1 | Frame accepted (meaningful with `res_valid`) |
| res_mcast | output | 1 | Destination is multicast or broadcast |

## Verification
The address and CRC registers update on the edge that takes the sixth byte, and the decision register follows one edge later. The result is therefore due one clock after that edge. The bench drives on the falling edge and samples on the falling edges one, two and three clocks after the last byte: it expects the strobe low, then high with the decision, then low again. Trailing junk bytes and skipped cycles are placed inside those windows, so each check lands on the exact cycle the strobe belongs to. Expected accept values come from a CRC and a mode formula that the bench computes itself, swept over all mode words and many pseudo-random multicast addresses.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam logic [31:0] CRC_POLY = 32'h04C1_1DB7;

  localparam logic [2:0] OFS_MODE  = 3'd0;
  localparam logic [2:0] OFS_STA_L = 3'd1;
  localparam logic [2:0] OFS_STA_H = 3'd2;
  localparam logic [2:0] OFS_HSH_L = 3'd3;
  localparam logic [2:0] OFS_HSH_H = 3'd4;

  // bit 0 promiscuous, 1 all multicast, 2 hash, 3 broadcast block
  typedef struct packed {
    logic bc_block;
    logic hash_en;
    logic all_mc;
    logic promisc;
  } rxf_mode_t;

  // One byte through the CRC register, LSB of the byte first.
  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    logic        fb;
    r = c;
    for (int i = 0; i < 8; i++) begin
      fb = r[31] ^ d[i];
      r  = {r[30:0], 1'b0} ^ (fb ? CRC_POLY : 32'h0);
    end
    return r;
  endfunction
endpackage

// File: rtl/rxf_regs.sv
module rxf_regs
  import rxf_pkg::*;
#(
  parameter int DW     = 32,
  parameter int AW     = 3,
  parameter int NB     = 6,
  parameter int HASH_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [AW-1:0]     addr,
  input  logic [DW-1:0]     wdata,
  output rxf_mode_t         mode,
  output logic [8*NB-1:0]   station,
  output logic [HASH_W-1:0] hash
);
  localparam int SW  = 8 * NB;
  localparam int SHW = SW - DW;
  localparam int MW  = $bits(rxf_mode_t);

  logic [DW-1:0]  sta_lo, hsh_lo, hsh_hi;
  logic [SHW-1:0] sta_hi;
  logic           unused_wbits;

  assign unused_wbits = ^wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode   <= '0;
      sta_lo <= '0;
      sta_hi <= '0;
      hsh_lo <= '0;
      hsh_hi <= '0;
    end else if (we) begin
      case (addr)
        OFS_MODE:  mode   <= rxf_mode_t'(wdata[MW-1:0]);
        OFS_STA_L: sta_lo <= wdata;
        OFS_STA_H: sta_hi <= wdata[SHW-1:0];
        OFS_HSH_L: hsh_lo <= wdata;
        OFS_HSH_H: hsh_hi <= wdata;
        default: ;
      endcase
    end
  end

  assign station = {sta_hi, sta_lo};
  assign hash    = {hsh_hi, hsh_lo};

  // R10: a mode write lands the next cycle
  a_r10_mode_write: assert property (@(posedge clk) disable iff (rst)
    (we && addr == OFS_MODE) |=> (mode == $past(wdata[MW-1:0])));
  // R10: offsets beyond the map leave the mode untouched
  a_r10_no_alias: assert property (@(posedge clk) disable iff (rst)
    (we && addr > OFS_HSH_H) |=> $stable(mode));
endmodule

// File: rtl/rxf_capture.sv
module rxf_capture
  import rxf_pkg::*;
#(
  parameter int NB = 6,
  parameter int HB = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sof,
  input  logic            vld,
  input  logic [7:0]      din,
  output logic [8*NB-1:0] addr_q,
  output logic [HB-1:0]   hidx,
  output logic            done_q
);
  localparam int CW = $clog2(NB + 1);
  localparam logic [CW-1:0] LAST = CW'(NB - 1);
  localparam logic [CW-1:0] IDLE = CW'(NB);

  logic [CW-1:0] cnt;
  logic [CW-1:0] pos;
  logic [31:0]   crc_q;
  logic          take;
  logic          unused_crc;

  assign take = vld && (sof || cnt < IDLE);
  assign pos  = sof ? '0 : cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= IDLE;
      crc_q  <= '1;
      addr_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= take && (pos == LAST);
      if (take) begin
        crc_q <= crc_step(sof ? 32'hFFFF_FFFF : crc_q, din);
        addr_q[int'(pos)*8 +: 8] <= din;
        cnt <= pos + 1'b1;
      end
    end
  end

  assign hidx       = crc_q[31 -: HB];
  assign unused_crc = ^crc_q[31-HB:0];

  // R2: completion only follows a taken byte
  a_r2_done_src: assert property (@(posedge clk) disable iff (rst)
    done_q |-> $past(vld));
  // R11: an idle input cycle never completes an address
  a_r11_gap_hold: assert property (@(posedge clk) disable iff (rst)
    !vld |=> !done_q);
endmodule

// File: rtl/rxf_decide.sv
module rxf_decide
  import rxf_pkg::*;
#(
  parameter int NB     = 6,
  parameter int HASH_W = 64,
  parameter int HB     = $clog2(HASH_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              done_i,
  input  logic [8*NB-1:0]   addr_i,
  input  logic [HB-1:0]     hidx_i,
  input  rxf_mode_t         mode_i,
  input  logic [8*NB-1:0]   station_i,
  input  logic [HASH_W-1:0] hash_i,
  output logic              res_valid,
  output logic              res_accept,
  output logic              res_mcast
);
  logic is_mc, is_bc, uc_hit, h_bit, keep;

  assign is_mc  = addr_i[0];
  assign is_bc  = &addr_i;
  assign uc_hit = (addr_i == station_i);
  assign h_bit  = hash_i[hidx_i];

  always_comb begin
    if (mode_i.promisc)     keep = 1'b1;
    else if (is_bc)         keep = !mode_i.bc_block;
    else if (is_mc)         keep = mode_i.all_mc || (mode_i.hash_en && h_bit);
    else                    keep = uc_hit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid  <= 1'b0;
      res_accept <= 1'b0;
      res_mcast  <= 1'b0;
    end else begin
      res_valid  <= done_i;
      res_accept <= done_i && keep;
      res_mcast  <= done_i && is_mc;
    end
  end

  // R2: the strobe lasts one cycle
  a_r2_one_cycle: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid);
  // R3: flags are only raised with the strobe
  a_r3_flags_qualified: assert property (@(posedge clk) disable iff (rst)
    (res_accept || res_mcast) |-> res_valid);
  // R5: promiscuous always accepts
  a_r5_promisc: assert property (@(posedge clk) disable iff (rst)
    (res_valid && $past(mode_i.promisc)) |-> res_accept);
  // R9: blocked broadcast is dropped outside promiscuous mode
  a_r9_bc_block: assert property (@(posedge clk) disable iff (rst)
    (res_valid && $past(is_bc && mode_i.bc_block && !mode_i.promisc)) |-> !res_accept);
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import rxf_pkg::*;
#(
  parameter int NB     = 6,
  parameter int HASH_W = 64,
  parameter int DW     = 32,
  parameter int AW     = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  input  logic          rx_sof,
  input  logic          rx_vld,
  input  logic [7:0]    rx_byte,
  output logic          res_valid,
  output logic          res_accept,
  output logic          res_mcast
);
  localparam int HB = $clog2(HASH_W);
  localparam int SW = 8 * NB;

  rxf_mode_t         mode;
  logic [SW-1:0]     station;
  logic [HASH_W-1:0] hash;
  logic [SW-1:0]     addr_q;
  logic [HB-1:0]     hidx;
  logic              done_q;

  rxf_regs #(.DW(DW), .AW(AW), .NB(NB), .HASH_W(HASH_W)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .mode(mode), .station(station), .hash(hash)
  );

  rxf_capture #(.NB(NB), .HB(HB)) u_cap (
    .clk(clk), .rst(rst), .sof(rx_sof), .vld(rx_vld), .din(rx_byte),
    .addr_q(addr_q), .hidx(hidx), .done_q(done_q)
  );

  rxf_decide #(.NB(NB), .HASH_W(HASH_W), .HB(HB)) u_dec (
    .clk(clk), .rst(rst), .done_i(done_q), .addr_i(addr_q), .hidx_i(hidx),
    .mode_i(mode), .station_i(station), .hash_i(hash),
    .res_valid(res_valid), .res_accept(res_accept), .res_mcast(res_mcast)
  );
endmodule

// File: tb/rx_addr_filter_tb.sv
module rx_addr_filter_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [47:0] STA  = 48'h5544_3322_1102;
  localparam logic [47:0] BCST = 48'hFFFF_FFFF_FFFF;
  localparam logic [47:0] MCA  = 48'h0100_005E_0001;

  logic clk = 0, rst = 1;
  logic reg_we = 0;
  logic [2:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic rx_sof = 0, rx_vld = 0;
  logic [7:0] rx_byte = 0;
  logic res_valid, res_accept, res_mcast;

  int errors = 0, checks = 0;
  bit done = 0;
  logic [31:0] rs = 32'h1357_9BDF;
  logic [3:0]  cur_mode = 0;
  logic [31:0] t_hi = 0, t_lo = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_addr_filter u_dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .rx_sof(rx_sof), .rx_vld(rx_vld), .rx_byte(rx_byte),
    .res_valid(res_valid), .res_accept(res_accept), .res_mcast(res_mcast)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] nxt();
    rs = rs ^ (rs << 13);
    rs = rs ^ (rs >> 17);
    rs = rs ^ (rs << 5);
    return rs;
  endfunction

  function automatic logic [5:0] ref_idx(input logic [47:0] a);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int k = 0; k < 48; k++) begin
      logic fb = c[31] ^ a[k];
      c = {c[30:0], 1'b0};
      if (fb) c = c ^ 32'h04C1_1DB7;
    end
    return c[31:26];
  endfunction

  function automatic bit ref_acc(input logic [3:0] m, input logic [47:0] a);
    logic [5:0] ix = ref_idx(a);
    bit hb = ix[5] ? t_hi[ix[4:0]] : t_lo[ix[4:0]];
    if (m[0]) return 1;
    if (a == BCST) return !m[3];
    if (a[0]) return m[1] || (m[2] && hb);
    return a == STA;
  endfunction

  task automatic wr(input logic [2:0] ad, input logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = ad; reg_wdata = d;
    @(negedge clk); reg_we = 0;
    if (ad == 3'd0) cur_mode = d[3:0];
    if (ad == 3'd3) t_lo = d;
    if (ad == 3'd4) t_hi = d;
  endtask

  task automatic send(input logic [47:0] a, input bit gap, input bit junk, input string req);
    bit ea = ref_acc(cur_mode, a);
    @(negedge clk); rx_sof = 1; rx_vld = 1; rx_byte = a[7:0];
    for (int k = 1; k < 6; k++) begin
      @(negedge clk); rx_sof = 0;
      if (gap && k == 3) begin
        rx_vld = 0; rx_byte = 8'hA5;
        @(negedge clk);
      end
      rx_vld = 1; rx_byte = a[8*k +: 8];
    end
    @(negedge clk);
    rx_vld = junk; rx_byte = 8'hFF;
    check(res_valid == 0, {req, " R2 early"}, res_valid, 0);
    @(negedge clk);
    rx_vld = 0;
    check(res_valid == 1, {req, " R2 strobe"}, res_valid, 1);
    check(res_accept == ea, {req, " accept"}, res_accept, ea);
    check(res_mcast == a[0], {req, " R3 mcast"}, res_mcast, a[0]);
    @(negedge clk);
    check(res_valid == 0, {req, " R2 one cycle"}, res_valid, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1
    check(res_valid == 0 && res_accept == 0 && res_mcast == 0, "R1 reset", {res_valid, res_accept, res_mcast}, 0);
    wr(3'd1, STA[31:0]);
    wr(3'd2, {16'h0, STA[47:32]});
    send(STA, 0, 0, "R8 match");
    send(STA ^ 48'h0100_0000_0000, 0, 0, "R8 miss");
    send(MCA, 0, 0, "R8 mcast");
    send(BCST, 0, 0, "R9 bcast");
    // R5 R6 R7 R8 R9 across all mode words, with gaps (R11) and trailing bytes (R2)
    for (int m = 0; m < 16; m++) begin
      wr(3'd0, 32'(m));
      send(STA, m[0], m[1], "R5-sweep uc");
      send(STA ^ 48'h0000_0000_0100, m[1], m[0], "R6 sweep uc miss");
      send(MCA, m[2], 0, "R7 sweep mc");
      send(BCST, 0, m[3], "R9 sweep bc");
    end
    // R4 R7 hash index over many multicast addresses
    wr(3'd3, 32'h5A3C_F096);
    wr(3'd4, 32'hC3A5_0F69);
    wr(3'd0, 32'h4);
    for (int n = 0; n < 160; n++) begin
      logic [47:0] a = {nxt()[15:0], nxt()};
      a[0] = 1;
      if (a == BCST) a[1] = 0;
      send(a, n[2], n[3], "R4 hash");
    end
    // R7 full table
    wr(3'd3, 32'hFFFF_FFFF);
    wr(3'd4, 32'hFFFF_FFFF);
    for (int n = 0; n < 12; n++) begin
      logic [47:0] a = {nxt()[15:0], nxt()};
      a[0] = 1;
      send(a, 0, 0, "R7 full table");
    end
    // R10 unmapped offsets: promisc alias would accept a miss
    wr(3'd0, 32'h0);
    wr(3'd5, 32'hFFFF_FFFF);
    wr(3'd6, 32'hFFFF_FFFF);
    wr(3'd7, 32'hFFFF_FFFF);
    send(STA ^ 48'h0000_0000_0200, 0, 0, "R10 unmapped");
    send(STA, 0, 0, "R10 station kept");
    // R2 restart: partial address then new start
    @(negedge clk); rx_sof = 1; rx_vld = 1; rx_byte = 8'h01;
    @(negedge clk); rx_sof = 0; rx_byte = 8'h77;
    @(negedge clk); rx_byte = 8'h88;
    check(res_valid == 0, "R2 partial", res_valid, 0);
    send(STA, 0, 0, "R2 restart");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(negedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule